// File: doc/BRIEF.md
# Serial ADC Sample Reader

This block is the host-side master that pulls one conversion result out of a three-wire serial analog-to-digital converter. A single-cycle start pulse on the system clock makes it lower chip select and run a serial clock. The serial clock's half-period is a parameter, counted in system clocks. The converter changes its data line on serial-clock falling edges, so the block samples on the rising edge that follows each fall.

The converter puts out a null bit before the 12-bit two's-complement word, which arrives MSB first. The reader drops the null bit, assembles the word and sign-extends it to 16 bits. It presents the result with a one-cycle valid strobe in the cycle in which chip select returns high.

An echo mode can be selected per transfer. In that mode chip select stays low long enough for the converter to resend the word LSB first. That copy starts at B1, skips B0 and ends at B11. The reader rebuilds the echo, compares it with B11..B1 of the first copy and raises an error flag on any difference. This serves as a cheap integrity test of the serial link.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset and while idle: cs_n_o is 1, sclk_o is 1, valid_o is 0 and busy_o is 0.
- R2: sclk_o changes level only while cs_n_o is 0, and stays 1 whenever cs_n_o is 1. Each level lasts exactly HALF_DIV system clocks, and the first falling edge comes HALF_DIV clocks after cs_n_o falls.
- R3: A plain transfer makes exactly 14 sclk falling edges. An echo transfer makes exactly 26.
- R4: The bits sampled at the rising edges after falls 3 through 14 form the result, MSB first. The bit after fall 2 (the null bit) and the bits after falls 1 and 26 are not used.
- R5: result_o is the 12-bit word sign-extended from bit 11 to 16 bits (for example, 0x800 gives 0xF800 and 0x7FF gives 0x07FF).
- R6: valid_o is a single-cycle pulse. It rises in the same cycle as cs_n_o rises, HALF_DIV clocks after the last sclk rising edge.
- R7: In echo mode, the bits sampled after falls 15 to 25 are taken as B1 to B11. If any of them differs from the first copy, echo_err_o is 1 alongside valid_o; otherwise it is 0. In plain mode echo_err_o is always 0. echo_err_o and result_o hold until the next valid_o.
- R8: A start_i pulse while busy_o is 1 is ignored. It causes no extra chip-select fall and no extra result.
- R9: Between transfers, cs_n_o stays high for at least 2*HALF_DIV system clocks. Each accepted start produces exactly one chip-select fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, one sample per accepted pulse |
| echo_en_i | input | 1 | Selects echo mode, latched at start |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles high |
| busy_o | output | 1 | Transfer or guard interval in progress |
| result_o | output | 16 | Sign-extended result |
| valid_o | output | 1 | One-cycle result strobe |
| echo_err_o | output | 1 | Echo mismatch flag |

## Verification
Two events can fall in the same cycle: the end of one transfer (chip select rising together with valid) and a new request. The bench provokes this by holding start high from the valid cycle onward. It then checks two things: that the next chip-select fall does not come before the guard interval has passed, and that this fall yields exactly one further, correct result. A start pulse placed in the middle of a transfer is judged by the falling-edge count, and by the absence of any further chip-select fall or strobe afterwards.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_TAIL  = 2'd2,
        ST_GUARD = 2'd3
    } rd_state_e;
endpackage

// File: rtl/adc_rd_tick.sv
module adc_rd_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_t;

    tick_t q, d;

    always_comb begin
        d = q;
        tick_o = en_i && (q.cnt == LAST);
        if (!en_i || tick_o) d.cnt = '0;
        else                 d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              take_main_i,
    input  logic              take_echo_i,
    input  logic              sd_i,
    output logic [DATA_W-1:0] main_o,
    output logic [DATA_W-2:0] echo_o
);
    typedef struct packed {
        logic [DATA_W-1:0] main;
        logic [DATA_W-2:0] echo;
    } cap_t;

    cap_t q, d;

    always_comb begin
        d = q;
        if (clr_i) begin
            d = '0;
        end else begin
            if (take_main_i) d.main = {q.main[DATA_W-2:0], sd_i};
            if (take_echo_i) d.echo = {sd_i, q.echo[DATA_W-2:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign main_o = q.main;
    assign echo_o = q.echo;
endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
    import adc_rd_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int DATA_W   = 12,
    parameter int OUT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             echo_en_i,
    input  logic             sdata_i,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic             busy_o,
    output logic [OUT_W-1:0] result_o,
    output logic             valid_o,
    output logic             echo_err_o
);
    localparam int FALL_W = $clog2(2 * DATA_W + 3);
    localparam logic [FALL_W-1:0] FIRST_MAIN  = FALL_W'(3);
    localparam logic [FALL_W-1:0] LAST_MAIN   = FALL_W'(DATA_W + 2);
    localparam logic [FALL_W-1:0] FIRST_ECHO  = FALL_W'(DATA_W + 3);
    localparam logic [FALL_W-1:0] LAST_ECHO   = FALL_W'(2 * DATA_W + 1);
    localparam logic [FALL_W-1:0] PLAIN_FALLS = FALL_W'(DATA_W + 2);
    localparam logic [FALL_W-1:0] ECHO_FALLS  = FALL_W'(2 * DATA_W + 2);

    typedef struct packed {
        rd_state_e         state;
        logic              cs_n;
        logic              sclk;
        logic [FALL_W-1:0] falls;
        logic              echo;
        logic              guard;
        logic [OUT_W-1:0]  result;
        logic              valid;
        logic              err;
    } rd_t;

    rd_t q, d;

    logic              tick;
    logic              take_main;
    logic              take_echo;
    logic              clr;
    logic [DATA_W-1:0] main_w;
    logic [DATA_W-2:0] echo_w;
    logic [FALL_W-1:0] last_fall;

    adc_rd_tick #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (q.state != ST_IDLE),
        .tick_o(tick)
    );

    adc_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr),
        .take_main_i(take_main),
        .take_echo_i(take_echo),
        .sd_i       (sdata_i),
        .main_o     (main_w),
        .echo_o     (echo_w)
    );

    always_comb begin
        d         = q;
        d.valid   = 1'b0;
        clr       = 1'b0;
        take_main = 1'b0;
        take_echo = 1'b0;
        last_fall = q.echo ? ECHO_FALLS : PLAIN_FALLS;
        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    clr     = 1'b1;
                    d.state = ST_XFER;
                    d.cs_n  = 1'b0;
                    d.falls = '0;
                    d.echo  = echo_en_i;
                end
            end
            ST_XFER: begin
                if (tick) begin
                    if (q.sclk) begin
                        d.sclk  = 1'b0;
                        d.falls = q.falls + 1'b1;
                    end else begin
                        d.sclk    = 1'b1;
                        take_main = (q.falls >= FIRST_MAIN) && (q.falls <= LAST_MAIN);
                        take_echo = q.echo && (q.falls >= FIRST_ECHO) && (q.falls <= LAST_ECHO);
                        if (q.falls == last_fall) d.state = ST_TAIL;
                    end
                end
            end
            ST_TAIL: begin
                if (tick) begin
                    d.cs_n   = 1'b1;
                    d.valid  = 1'b1;
                    d.result = {{(OUT_W - DATA_W){main_w[DATA_W-1]}}, main_w};
                    d.err    = q.echo && (echo_w != main_w[DATA_W-1:1]);
                    d.guard  = 1'b0;
                    d.state  = ST_GUARD;
                end
            end
            ST_GUARD: begin
                if (tick) begin
                    if (q.guard) d.state = ST_IDLE;
                    else         d.guard = 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.cs_n  <= 1'b1;
            q.sclk  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cs_n_o     = q.cs_n;
    assign sclk_o     = q.sclk;
    assign busy_o     = (q.state != ST_IDLE);
    assign result_o   = q.result;
    assign valid_o    = q.valid;
    assign echo_err_o = q.err;
endmodule

// File: rtl/adc_serial_reader_chk.sv
module adc_serial_reader_chk #(
    parameter int HALF_DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic cs_n_o,
    input logic sclk_o,
    input logic busy_o,
    input logic valid_o
);
    localparam int GW = 16;
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              gap_q <= '1;
        else if (!cs_n_o)        gap_q <= '0;
        else if (gap_q != '1)    gap_q <= gap_q + 1'b1;
    end

    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cs_n_o && sclk_o && !valid_o));

    assert_sclk_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> sclk_o);

    assert_fall_in_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> !cs_n_o);

    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_valid_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $rose(cs_n_o));

    assert_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> ($past(start_i) && !$past(busy_o)));

    assert_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> (gap_q >= GW'(2 * HALF_DIV)));
endmodule

bind adc_serial_reader adc_serial_reader_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .cs_n_o (cs_n_o),
    .sclk_o (sclk_o),
    .busy_o (busy_o),
    .valid_o(valid_o)
);

// File: tb/adc_serial_reader_bench.sv
module adc_serial_reader_bench;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        echo_en = 1'b0;
    logic        sdata = 1'b0;
    logic        cs_n, sclk, busy, valid, err;
    logic [15:0] result;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [11:0] m_word = '0;
    int          m_bad_fall = 0;
    int          m_falls = 0;
    int          per_cnt = 0;
    int          per_bad = 0;
    logic        prev_sclk = 1'b1;
    logic        prev_cs = 1'b1;

    always #10 clk = ~clk;

    adc_serial_reader #(.HALF_DIV(HALF)) u_adc_serial_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .echo_en_i (echo_en),
        .sdata_i   (sdata),
        .cs_n_o    (cs_n),
        .sclk_o    (sclk),
        .busy_o    (busy),
        .result_o  (result),
        .valid_o   (valid),
        .echo_err_o(err)
    );

    function automatic logic model_bit(logic [11:0] w, int f, int bad);
        logic b;
        if (f >= 3 && f <= 14)       b = w[14 - f];
        else if (f >= 15 && f <= 25) b = w[f - 14];
        else                         b = 1'b0;
        if (f == bad) b = ~b;
        return b;
    endfunction

    function automatic logic [15:0] sext(logic [11:0] w);
        return {{4{w[11]}}, w};
    endfunction

    // converter model, also measures sclk level durations (R2)
    always @(negedge clk) begin
        if (prev_cs && !cs_n) begin
            m_falls = 0;
            per_cnt = 0;
        end else if (sclk != prev_sclk) begin
            if (per_cnt + 1 != HALF) per_bad++;
            per_cnt = 0;
            if (!sclk && !cs_n) begin
                m_falls++;
                sdata <= model_bit(m_word, m_falls, m_bad_fall);
            end
            if (cs_n) per_bad++;
        end else if (!cs_n) begin
            per_cnt++;
        end
        prev_sclk = sclk;
        prev_cs   = cs_n;
    end

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_valid();
        @(negedge clk);
        while (!valid) @(negedge clk);
    endtask

    task automatic check_result(logic [11:0] w, bit ech, int bad);
        bit exp_err;
        exp_err = ech && (bad >= 15 && bad <= 25);
        chk(result == sext(w), "R4/R5 result", result, sext(w));
        chk(err == exp_err, "R7 echo_err", err, exp_err);
        chk(m_falls == (ech ? 26 : 14), "R3 fall count", m_falls, ech ? 26 : 14);
        chk(cs_n == 1'b1, "R6 cs high with valid", cs_n, 1);
        @(negedge clk);
        chk(valid == 1'b0, "R6 single-cycle valid", valid, 0);
    endtask

    task automatic run_xfer(logic [11:0] w, bit ech, int bad);
        while (busy) @(negedge clk);
        @(negedge clk);
        m_word = w; m_bad_fall = bad;
        echo_en = ech; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_valid();
        check_result(w, ech, bad);
    endtask

    initial begin
        int gap;
        process::self().srandom(32'd7);
        repeat (3) @(negedge clk);
        chk(cs_n == 1 && sclk == 1 && valid == 0 && busy == 0, "R1 reset state",
            {cs_n, sclk, valid, busy}, 4'b1100);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(cs_n == 1 && sclk == 1 && busy == 0, "R1 idle", {cs_n, sclk, busy}, 3'b110);

        // directed corner words
        run_xfer(12'h800, 1'b0, 0);   // R5 most negative
        run_xfer(12'h7FF, 1'b1, 0);   // R5 most positive, echo clean
        run_xfer(12'h000, 1'b0, 0);
        run_xfer(12'hFFF, 1'b1, 15);  // R7 corrupt B1 echo
        run_xfer(12'hA55, 1'b1, 25);  // R7 corrupt B11 echo
        run_xfer(12'h5A5, 1'b0, 20);  // R7 plain mode ignores echo region
        run_xfer(12'h123, 1'b1, 2);   // R4 null bit corrupt has no effect
        chk(err == 1'b0, "R4 null bit ignored", err, 0);

        // R8: start mid transfer ignored
        while (busy) @(negedge clk);
        m_word = 12'h3C3; m_bad_fall = 0; echo_en = 1'b0;
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (10) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_valid();
        check_result(12'h3C3, 1'b0, 0);
        begin
            bit extra;
            extra = 0;
            repeat (40) begin
                @(negedge clk);
                if (!cs_n || valid) extra = 1;
            end
            chk(!extra, "R8 busy start ignored", extra, 0);
        end

        // R9: request held from the valid cycle onward
        while (busy) @(negedge clk);
        m_word = 12'h0F0; echo_en = 1'b1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        wait_valid();
        m_word = 12'hF0F; start = 1'b1;
        gap = 0;
        while (cs_n) begin gap++; @(negedge clk); end
        start = 1'b0;
        chk(gap >= 2 * HALF, "R9 guard interval", gap, 2 * HALF);
        wait_valid();
        check_result(12'hF0F, 1'b1, 0);

        // random mix
        for (int i = 0; i < 24; i++) begin
            logic [11:0] w;
            bit e;
            int b;
            w = 12'($urandom);
            e = 1'($urandom);
            b = ($urandom % 3 == 0) ? 15 + int'($urandom % 11) : 0;
            run_xfer(w, e, b);
        end

        chk(per_bad == 0, "R2 sclk level timing", per_bad, 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule